// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned W-bit operands and a one-bit carry-in. It produces a W-bit sum and a carry-out. It has no clock and no storage. The carries do not ripple from bit to bit, and they are not built from one flat layer of wide lookahead gates. Instead, each bit first forms its own generate and propagate signals. These are then combined over log2(W) stages. At every stage, each bit position joins the group it already covers with the equally long group directly beneath it, so the span doubles.

The carry-in is merged into the generate of bit 0 before the first stage. Where a group would reach below bit 0 it is cut off at bit 0, so that position passes its value through unchanged. After the last stage, the generate at bit i is the carry into bit i+1. The sum bit is the bit's propagate XOR its incoming carry. W must be a power of two, at least 2.

The block has no operating states. Its single mode is: outputs follow inputs through gates only.

Top module: `prefix_adder`

## Requirements
- R1: `sum` equals the low W bits of `a + b + cin` for every input combination.
- R2: `cout` equals bit W of the (W+1)-bit value `a + b + cin`.
- R3: When `a` is the bitwise inverse of `b`, every bit propagates. `cin`=1 then gives `sum`=0 and `cout`=1, and `cin`=0 gives `sum` all ones and `cout`=0.
- R4: When both operands have their most significant bit (bit W-1) set, `cout` is 1.
- R5: When both operands have bit W-1 clear, `cout` is 0.
- R6: With `b`=0 and `cin`=0, `sum` equals `a` and `cout` is 0. With all inputs zero, both outputs are zero.
- R7: The outputs hold no state. A new input value is reflected at the outputs without any clock edge, and earlier inputs have no influence.
- R8: A carry produced at bit 0 (by `cin`, or by `a[0]`·`b[0]`) reaches `cout` through a span of W-1 propagating bits. Example: `a`=all ones, `b`=1, `cin`=0 gives `sum`=0 and `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The 4-bit and 8-bit instances get every operand pair with both carry-in values. This exposes any wrong span, clipping boundary or stage order, because each prefix span is exercised with every generate/propagate mix. The 32-bit instance gets random operands. Those vectors separate a correct deep prefix tree from one with a single mis-wired cell in a high stage, which small widths never reach.

Directed patterns cover the remaining cases:
- Complementary operands force the longest propagate chain, so carry-in handling is isolated from generate handling.
- A bit-0 generate into an all-ones operand checks that a carry travels through every stage.
- Zero-operand and same-MSB cases pin down the identity and the carry-out limits.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

    // Number of span-doubling stages needed to cover a W-bit word
    function automatic int unsigned stage_count(input int unsigned width);
        int unsigned n;
        n = 0;
        while ((1 << n) < width) n++;
        return n;
    endfunction

    // Combine an upper group (g_hi,p_hi) with the group directly below it
    function automatic logic [1:0] merge_group(input logic g_hi, input logic p_hi,
                                               input logic g_lo, input logic p_lo);
        return {g_hi | (p_hi & g_lo), p_hi & p_lo};
    endfunction

endpackage

// File: rtl/pg_cells.sv
module pg_cells #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         carry_in,
    output logic [W-1:0] bit_gen,
    output logic [W-1:0] bit_prop,
    output logic [W-1:0] seed_gen
);
    // Per-bit generate and propagate
    assign bit_gen  = op_x & op_y;
    assign bit_prop = op_x ^ op_y;

    // Carry-in folded into bit 0 as a generate term from below
    generate
        if (W > 1) begin : g_upper
            assign seed_gen[W-1:1] = bit_gen[W-1:1];
        end
    endgenerate
    assign seed_gen[0] = bit_gen[0] | (bit_prop[0] & carry_in);

endmodule

// File: rtl/prefix_stage.sv
module prefix_stage
    import prefix_adder_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned SPAN = 1
) (
    input  logic [W-1:0] grp_gen_in,
    input  logic [W-1:0] grp_prop_in,
    output logic [W-1:0] grp_gen_out,
    output logic [W-1:0] grp_prop_out
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i >= SPAN) begin : g_merge
            logic [1:0] merged;
            assign merged          = merge_group(grp_gen_in[i], grp_prop_in[i],
                                                 grp_gen_in[i-SPAN], grp_prop_in[i-SPAN]);
            assign grp_gen_out[i]  = merged[1];
            assign grp_prop_out[i] = merged[0];
        end else begin : g_clip
            // Group already reaches bit 0: nothing below to merge
            assign grp_gen_out[i]  = grp_gen_in[i];
            assign grp_prop_out[i] = grp_prop_in[i];
        end
    end

endmodule

// File: rtl/sum_cells.sv
module sum_cells #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] bit_prop,
    input  logic [W-1:0] carry_vec,
    output logic [W-1:0] sum_bits
);
    assign sum_bits = bit_prop ^ carry_vec;

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
    import prefix_adder_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned STAGES = stage_count(W);

    logic [W-1:0]           gen_bit;
    logic [W-1:0]           prop_bit;
    logic [W-1:0]           gen_seed;
    logic [STAGES:0][W-1:0] gen_lvl;
    logic [STAGES:0][W-1:0] prop_lvl;
    logic [W:0]             carry;

    pg_cells #(.W(W)) u_pg (
        .op_x     (a),
        .op_y     (b),
        .carry_in (cin),
        .bit_gen  (gen_bit),
        .bit_prop (prop_bit),
        .seed_gen (gen_seed)
    );

    assign gen_lvl[0]  = gen_seed;
    assign prop_lvl[0] = prop_bit;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        prefix_stage #(.W(W), .SPAN(1 << s)) u_stage (
            .grp_gen_in   (gen_lvl[s]),
            .grp_prop_in  (prop_lvl[s]),
            .grp_gen_out  (gen_lvl[s+1]),
            .grp_prop_out (prop_lvl[s+1])
        );
    end

    // Carry into bit i+1 is the full-prefix generate ending at bit i
    assign carry[0]   = cin;
    assign carry[W:1] = gen_lvl[STAGES];

    sum_cells #(.W(W)) u_sum (
        .bit_prop  (prop_bit),
        .carry_vec (carry[W-1:0]),
        .sum_bits  (sum)
    );

    assign cout = carry[W];

endmodule

// File: rtl/prefix_adder_checker.sv
module prefix_adder_checker #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);
    logic [W:0] total;
    assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            assert_sum_match_R1: assert (sum == total[W-1:0])
                else $error("sum mismatch");
            assert_cout_match_R2: assert (cout == total[W])
                else $error("cout mismatch");
            assert_msb_pair_carry_R4: assert (!(a[W-1] && b[W-1]) || cout)
                else $error("cout missing with both MSBs set");
            assert_msb_clear_nocarry_R5: assert (a[W-1] || b[W-1] || !cout)
                else $error("cout set with both MSBs clear");
            assert_identity_R6: assert (b != '0 || cin || (sum == a && !cout))
                else $error("identity add broken");
        end
    end

endmodule

bind prefix_adder prefix_adder_checker #(.W(W)) u_prefix_adder_checker (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/prefix_adder_bench.sv
module prefix_adder_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [3:0]  a4, b4, s4;
    logic        c4, co4;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    bit          done   = 1'b0;

    prefix_adder #(.W(32)) u_prefix_adder    (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
    prefix_adder #(.W(8))  u_prefix_adder_w8 (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
    prefix_adder #(.W(4))  u_prefix_adder_w4 (.a(a4),  .b(b4),  .cin(c4),  .sum(s4),  .cout(co4));

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_miss++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Behavioural reference: plain integer addition
    task automatic check32(input string req);
        longint unsigned t;
        t = longint'(a32) + longint'(b32) + longint'(c32);
        check({req, " sum32 R1"}, {1'b0, s32}, {1'b0, t[31:0]});
        check({req, " cout32 R2"}, {32'd0, co32}, {32'd0, t[32]});
    endtask

    task automatic check_small(input string req);
        int unsigned t8, t4;
        t8 = a8 + b8 + c8;
        t4 = a4 + b4 + c4;
        check({req, " sum8 R1"}, {25'd0, s8}, {25'd0, t8[7:0]});
        check({req, " cout8 R2"}, {32'd0, co8}, {32'd0, t8[8]});
        check({req, " sum4 R1"}, {29'd0, s4}, {29'd0, t4[3:0]});
        check({req, " cout4 R2"}, {32'd0, co4}, {32'd0, t4[4]});
    endtask

    task automatic apply32(input logic [31:0] x, input logic [31:0] y, input logic ci);
        @(posedge clk);
        a32 = x; b32 = y; c32 = ci;
        @(negedge clk);
    endtask

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        a4  = '0; b4  = '0; c4  = 1'b0;

        // R6: all-zero inputs give zero outputs
        @(negedge clk);
        check("R6 zero", {s32, co32}, 33'd0);

        // R3: complementary operands, carry-in rides full propagate chain
        apply32(32'hA5C3_0F96, ~32'hA5C3_0F96, 1'b1);
        check("R3 cin=1", {co32, s32}, {1'b1, 32'h0});
        apply32(32'h1234_5678, ~32'h1234_5678, 1'b0);
        check("R3 cin=0", {co32, s32}, {1'b0, 32'hFFFF_FFFF});

        // R8: bit-0 generate travels to cout
        apply32(32'hFFFF_FFFF, 32'h1, 1'b0);
        check("R8 gen0", {co32, s32}, {1'b1, 32'h0});
        apply32(32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R8 cin", {co32, s32}, {1'b1, 32'h0});

        // R4 / R5: MSB pairs
        apply32(32'h8000_0000, 32'h8000_0000, 1'b0);
        check("R4 msb set", {32'd0, co32}, 33'd1);
        apply32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        check("R5 msb clear", {32'd0, co32}, 33'd0);
        check32("R5");

        // R6: identity
        apply32(32'hDEAD_BEEF, 32'h0, 1'b0);
        check("R6 identity", {co32, s32}, {1'b0, 32'hDEAD_BEEF});

        // R7: no clock edge between input changes, outputs still follow
        @(negedge clk);
        #1 a32 = 32'hFFFF_0000; b32 = 32'h0001_0000; c32 = 1'b0;
        #1 check("R7 step1", {co32, s32}, {1'b1, 32'h0});
        #1 a32 = 32'h0000_0003; b32 = 32'h0000_0004; c32 = 1'b1;
        #1 check("R7 step2", {co32, s32}, {1'b0, 32'h8});

        // Exhaustive 4/8-bit, random 32-bit
        for (int k = 0; k < 131072; k++) begin
            @(posedge clk);
            a8 = k[7:0];  b8 = k[15:8]; c8 = k[16];
            a4 = k[3:0];  b4 = k[7:4];  c4 = k[8];
            a32 = $urandom; b32 = $urandom; c32 = k[0];
            @(negedge clk);
            check_small("sweep");
            check32("random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog got=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule